// File: doc/BRIEF.md
# SDRAM Idle Low-Power Entry Controller

This block watches the request strobe of a memory controller and counts the cycles in which no request arrives. When the count reaches a programmable window, it sends an entry command for one of three low-power states (clock stop, self-refresh or power-down) to a downstream command sequencer. The next request, or a frequency-change request, brings the memory back out with an exit command. A request that arrives while the memory is in a low-power state is held off until the exit has been issued.

Software writes a mode and the current DDR clock frequency in MHz. From these the block picks one of two idle timeouts. Above the threshold it uses the longer, performance-oriented timeout; below it, the shorter, power-oriented one. It encodes the chosen timeout as a power-of-two window code and publishes a control word with one timer field per low-power state. While a frequency change is pending, the block behaves as if low power were disabled. A new configuration is adopted only when the idle counter restarts, so a count already running always finishes with the window it started with.

Top module: `lp_idle_ctrl`

## Requirements
- R1: After reset the block is active (`lp_kind` = 0), issues no entry or exit command, reports `pm_word` = 16'hF0FF, and forwards `req_valid` straight to `req_go`.
- R2: On a configuration write, the block selects the fast timeout (`TMO_FAST`) when `cfg_freq_mhz` is greater than or equal to `FREQ_THRESH`, and the slow timeout (`TMO_SLOW`) otherwise.
- R3: A timeout of T cycles encodes to code ceil(log2 T) − 3, saturated at 15. Any T below 16 encodes to 0. Code c gives an idle window of 2^(c+3) cycles.
- R4: In self-refresh mode the code is raised to at least 6.
- R5: `pm_word` layout: [15:12] clock-stop timer, [11] zero, [10:8] the mode as written, [7:4] self-refresh timer, [3:0] power-down timer. The fields of the unselected states read 4'hF.
- R6: Mode 1 selects clock stop (`lp_kind` 1), mode 2 selects self-refresh (`lp_kind` 2) and mode 4 selects power-down (`lp_kind` 3). After 2^(c+3) consecutive idle cycles, `lp_enter` pulses for one cycle and `lp_kind` shows the state.
- R7: Mode codes 0, 3, 5, 6 and 7 never cause an entry.
- R8: A request seen in a low-power state produces a one-cycle `lp_exit` and a return to `lp_kind` 0 on the next edge. `req_go` is high only when active. Each accepted request restarts the idle count.
- R9: While `freq_chg_req` is high, no entry occurs, any low-power state is exited, and `freq_chg_ack` is high exactly when the block is active. After the request drops, counting resumes with the programmed mode.
- R10: A configuration written during a count takes effect only at the next counter restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DDR controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A memory request is waiting |
| req_go | output | 1 | Request is passed on this cycle |
| freq_chg_req | input | 1 | Frequency change requested (held until done) |
| freq_chg_ack | output | 1 | Block is active and holds off low power |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Low-power mode code |
| cfg_freq_mhz | input | FREQ_W | Current DDR frequency in MHz |
| lp_enter | output | 1 | One-cycle low-power entry command |
| lp_exit | output | 1 | One-cycle low-power exit command |
| lp_kind | output | 2 | Current state: 0 active, 1 clock stop, 2 self-refresh, 3 power-down |
| pm_word | output | 16 | Encoded power-management control word |

## Verification
The bench configures each of the three entry modes at frequencies on both sides of the threshold, including exactly at it and one below it. The resulting windows differ by powers of two, so a wrong timeout choice, a wrong encoding or a missing self-refresh clamp each shows up as an entry on the wrong cycle. Reconfiguring in the middle of a count tells a correct deferred load apart from an immediate one. Holding a frequency change across several windows shows whether entry is truly suppressed and whether it resumes afterwards. Undefined mode codes confirm that they behave like the disabled mode.

// File: rtl/lp_idle_pkg.sv
package lp_idle_pkg;

  localparam int MODE_W = 3;
  localparam int CODE_W = 4;
  localparam int WORD_W = 16;
  // largest window is 2^(15+3) cycles; one extra bit for the limit value
  localparam int CNT_W  = (1 << CODE_W) - 1 + 3 + 1;

  localparam logic [MODE_W-1:0] MODE_OFF     = 3'd0;
  localparam logic [MODE_W-1:0] MODE_CLKSTOP = 3'd1;
  localparam logic [MODE_W-1:0] MODE_SELFREF = 3'd2;
  localparam logic [MODE_W-1:0] MODE_PWRDN   = 3'd4;

  localparam logic [CODE_W-1:0] CODE_MAX     = '1;
  localparam logic [CODE_W-1:0] SR_MIN_CODE  = 4'd6;

  typedef enum logic [1:0] {
    LPK_NONE    = 2'd0,
    LPK_CLKSTOP = 2'd1,
    LPK_SELFREF = 2'd2,
    LPK_PWRDN   = 2'd3
  } lp_kind_e;

  // ceil(log2(cycles)) - 3, zero below 16, saturated at the field maximum
  function automatic logic [CODE_W-1:0] tmo_to_code(input int unsigned cycles);
    int unsigned lg;
    lg = 0;
    for (int i = 0; i < 32; i++) begin
      if ((64'd1 << i) < 64'(cycles)) lg = i + 1;
    end
    if (cycles < 16) return '0;
    if (lg - 3 > 15) return CODE_MAX;
    return CODE_W'(lg - 3);
  endfunction

  function automatic lp_kind_e mode_to_kind(input logic [MODE_W-1:0] m);
    case (m)
      MODE_CLKSTOP: return LPK_CLKSTOP;
      MODE_SELFREF: return LPK_SELFREF;
      MODE_PWRDN:   return LPK_PWRDN;
      default:      return LPK_NONE;
    endcase
  endfunction

endpackage

// File: rtl/lp_cfg_enc.sv
module lp_cfg_enc
  import lp_idle_pkg::*;
#(
  parameter int FREQ_W      = 12,
  parameter int FREQ_THRESH = 400,
  parameter int TMO_FAST    = 2048,
  parameter int TMO_SLOW    = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [FREQ_W-1:0] cfg_freq_mhz,
  output logic [MODE_W-1:0] pend_mode,
  output logic [CODE_W-1:0] pend_code,
  output logic [WORD_W-1:0] pm_word
);

  localparam logic [CODE_W-1:0] CODE_FAST = tmo_to_code(TMO_FAST);
  localparam logic [CODE_W-1:0] CODE_SLOW = tmo_to_code(TMO_SLOW);
  localparam logic [FREQ_W-1:0] THRESH_V  = FREQ_W'(FREQ_THRESH);
  localparam logic [CODE_W-1:0] ONES      = '1;

  logic [CODE_W-1:0] sel_code, sr_code, code_new;
  logic [WORD_W-1:0] word_new;
  logic [MODE_W-1:0] mode_d;
  logic [CODE_W-1:0] code_d;
  logic [WORD_W-1:0] word_d;

  // timeout choice and per-mode field layout
  always_comb begin
    sel_code = (cfg_freq_mhz >= THRESH_V) ? CODE_FAST : CODE_SLOW;
    sr_code  = (sel_code < SR_MIN_CODE) ? SR_MIN_CODE : sel_code;
    case (cfg_mode)
      MODE_CLKSTOP: begin
        code_new = sel_code;
        word_new = {sel_code, 1'b0, cfg_mode, ONES, ONES};
      end
      MODE_SELFREF: begin
        code_new = sr_code;
        word_new = {ONES, 1'b0, cfg_mode, sr_code, ONES};
      end
      MODE_PWRDN: begin
        code_new = sel_code;
        word_new = {ONES, 1'b0, cfg_mode, ONES, sel_code};
      end
      default: begin
        code_new = '0;
        word_new = {ONES, 1'b0, cfg_mode, ONES, ONES};
      end
    endcase
  end

  always_comb begin
    mode_d = pend_mode;
    code_d = pend_code;
    word_d = pm_word;
    if (cfg_we) begin
      mode_d = cfg_mode;
      code_d = code_new;
      word_d = word_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_mode <= MODE_OFF;
      pend_code <= '0;
      pm_word   <= {ONES, 1'b0, MODE_OFF, ONES, ONES};
    end else begin
      pend_mode <= mode_d;
      pend_code <= code_d;
      pm_word   <= word_d;
    end
  end

endmodule

// File: rtl/lp_idle_timer.sv
module lp_idle_timer
  import lp_idle_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic [MODE_W-1:0] pend_mode,
  input  logic [CODE_W-1:0] pend_code,
  output lp_kind_e          act_kind,
  output logic              expire
);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CODE_W-1:0] code_q, code_d;
  lp_kind_e          kind_d;
  logic [CNT_W-1:0]  lim_m1;

  assign lim_m1 = (CNT_W'(1) << (CNT_W'(code_q) + CNT_W'(3))) - CNT_W'(1);
  assign expire = run && (cnt_q == lim_m1);

  // a restart adopts the pending configuration
  always_comb begin
    cnt_d  = cnt_q;
    code_d = code_q;
    kind_d = act_kind;
    if (clr) begin
      cnt_d  = '0;
      code_d = pend_code;
      kind_d = mode_to_kind(pend_mode);
    end else if (run) begin
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      code_q   <= '0;
      act_kind <= LPK_NONE;
    end else begin
      cnt_q    <= cnt_d;
      code_q   <= code_d;
      act_kind <= kind_d;
    end
  end

endmodule

// File: rtl/lp_state_ctrl.sv
module lp_state_ctrl
  import lp_idle_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     freq_req,
  input  logic     expire,
  input  lp_kind_e act_kind,
  output lp_kind_e cur_kind,
  output logic     lp_enter,
  output logic     lp_exit,
  output logic     req_go,
  output logic     freq_ack,
  output logic     clr,
  output logic     run
);

  logic     active, wake;
  lp_kind_e cur_d;
  logic     enter_d, exit_d;

  assign active   = (cur_kind == LPK_NONE);
  assign wake     = req_valid | freq_req;
  assign run      = active & ~wake & (act_kind != LPK_NONE);
  assign clr      = ~active | wake | (act_kind == LPK_NONE);
  assign req_go   = req_valid & active;
  assign freq_ack = freq_req & active;

  always_comb begin
    cur_d   = cur_kind;
    enter_d = 1'b0;
    exit_d  = 1'b0;
    if (active) begin
      if (expire) begin
        cur_d   = act_kind;
        enter_d = 1'b1;
      end
    end else if (wake) begin
      cur_d  = LPK_NONE;
      exit_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_kind <= LPK_NONE;
      lp_enter <= 1'b0;
      lp_exit  <= 1'b0;
    end else begin
      cur_kind <= cur_d;
      lp_enter <= enter_d;
      lp_exit  <= exit_d;
    end
  end

endmodule

// File: rtl/lp_idle_ctrl.sv
module lp_idle_ctrl
  import lp_idle_pkg::*;
#(
  parameter int FREQ_W      = 12,
  parameter int FREQ_THRESH = 400,
  parameter int TMO_FAST    = 2048,
  parameter int TMO_SLOW    = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_go,
  input  logic              freq_chg_req,
  output logic              freq_chg_ack,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_mode,
  input  logic [FREQ_W-1:0] cfg_freq_mhz,
  output logic              lp_enter,
  output logic              lp_exit,
  output logic [1:0]        lp_kind,
  output logic [15:0]       pm_word
);

  logic [MODE_W-1:0] pend_mode;
  logic [CODE_W-1:0] pend_code;
  lp_kind_e          act_kind, cur_kind;
  logic              expire, clr, run;

  lp_cfg_enc #(
    .FREQ_W(FREQ_W), .FREQ_THRESH(FREQ_THRESH),
    .TMO_FAST(TMO_FAST), .TMO_SLOW(TMO_SLOW)
  ) u_enc (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_freq_mhz(cfg_freq_mhz), .pend_mode(pend_mode),
    .pend_code(pend_code), .pm_word(pm_word)
  );

  lp_idle_timer u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run(run),
    .pend_mode(pend_mode), .pend_code(pend_code),
    .act_kind(act_kind), .expire(expire)
  );

  lp_state_ctrl u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .freq_req(freq_chg_req), .expire(expire), .act_kind(act_kind),
    .cur_kind(cur_kind), .lp_enter(lp_enter), .lp_exit(lp_exit),
    .req_go(req_go), .freq_ack(freq_chg_ack), .clr(clr), .run(run)
  );

  assign lp_kind = cur_kind;

endmodule

// File: rtl/lp_idle_ctrl_chk.sv
module lp_idle_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_go,
  input logic        freq_chg_req,
  input logic        freq_chg_ack,
  input logic        cfg_we,
  input logic        lp_enter,
  input logic        lp_exit,
  input logic [1:0]  lp_kind,
  input logic [15:0] pm_word
);

  p_unsel_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_word[10:8] == 3'd0) |-> (pm_word[15:12] == 4'hF && pm_word[7:4] == 4'hF && pm_word[3:0] == 4'hF));

  p_sr_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_word[10:8] == 3'd2) |-> (pm_word[7:4] >= 4'd6));

  p_enter_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lp_enter |-> (lp_kind != 2'd0 && !lp_exit));

  p_exit_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lp_exit |-> (lp_kind == 2'd0));

  p_req_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_kind != 2'd0 && req_valid) |=> lp_exit);

  p_go_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_go |-> (req_valid && lp_kind == 2'd0));

  p_ack_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    freq_chg_ack |-> (freq_chg_req && lp_kind == 2'd0));

  p_no_entry_freq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    freq_chg_req |=> !lp_enter);

  p_word_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(pm_word));

endmodule

bind lp_idle_ctrl lp_idle_ctrl_chk u_chk (.*);

// File: tb/tb_lp_idle_ctrl.sv
module tb_lp_idle_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int FREQ_W     = 12;
  localparam int THRESH     = 400;
  localparam int T_FAST     = 100;
  localparam int T_SLOW     = 12;

  logic clk, rst_n;
  logic req_valid, freq_chg_req, cfg_we;
  logic [2:0] cfg_mode;
  logic [FREQ_W-1:0] cfg_freq_mhz;
  logic req_go, freq_chg_ack, lp_enter, lp_exit;
  logic [1:0] lp_kind;
  logic [15:0] pm_word;

  int n_tests = 0, n_fail = 0;
  bit chk_en = 0;

  lp_idle_ctrl #(.FREQ_W(FREQ_W), .FREQ_THRESH(THRESH),
                 .TMO_FAST(T_FAST), .TMO_SLOW(T_SLOW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_go(req_go),
    .freq_chg_req(freq_chg_req), .freq_chg_ack(freq_chg_ack),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_freq_mhz(cfg_freq_mhz),
    .lp_enter(lp_enter), .lp_exit(lp_exit), .lp_kind(lp_kind), .pm_word(pm_word)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- requirement-level reference ----------------
  function automatic int enc(int t);
    int c = 0;
    if (t < 16) return 0;
    while ((1 << (c + 3)) < t) c++;
    return (c > 15) ? 15 : c;
  endfunction

  function automatic int code_for(int mode, int f);
    int c = enc((f >= THRESH) ? T_FAST : T_SLOW);
    if (mode == 2 && c < 6) c = 6;
    return c;
  endfunction

  function automatic int kind_of(int mode);
    if (mode == 1) return 1;
    if (mode == 2) return 2;
    if (mode == 4) return 3;
    return 0;
  endfunction

  function automatic logic [15:0] word_of(int mode, int f);
    logic [3:0] cs = 4'hF, sr = 4'hF, pd = 4'hF;
    int c = code_for(mode, f);
    if (mode == 1) cs = 4'(c);
    if (mode == 2) sr = 4'(c);
    if (mode == 4) pd = 4'(c);
    return {cs, 1'b0, 3'(mode), sr, pd};
  endfunction

  int m_state, m_cnt, m_akind, m_alim, m_pmode, m_pcode;
  bit m_enter, m_exit;
  logic [15:0] m_word;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 0; m_cnt <= 0; m_akind <= 0; m_alim <= 8;
      m_pmode <= 0; m_pcode <= 0; m_enter <= 0; m_exit <= 0;
      m_word <= 16'hF0FF;
    end else begin
      m_enter <= 0; m_exit <= 0;
      if (m_state == 0) begin
        if (!req_valid && !freq_chg_req && m_akind != 0) begin
          m_cnt <= m_cnt + 1;
          if (m_cnt + 1 == m_alim) begin m_state <= m_akind; m_enter <= 1; end
        end else begin
          m_cnt <= 0; m_akind <= kind_of(m_pmode); m_alim <= 1 << (m_pcode + 3);
        end
      end else begin
        m_cnt <= 0; m_akind <= kind_of(m_pmode); m_alim <= 1 << (m_pcode + 3);
        if (req_valid || freq_chg_req) begin m_state <= 0; m_exit <= 1; end
      end
      if (cfg_we) begin
        m_pmode <= cfg_mode;
        m_pcode <= code_for(cfg_mode, cfg_freq_mhz);
        m_word  <= word_of(cfg_mode, cfg_freq_mhz);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the clock edge
  always @(posedge clk) begin
    #2;
    if (rst_n && chk_en) begin
      check("R6 lp_kind", 32'(lp_kind), 32'(m_state));
      check("R6 lp_enter", 32'(lp_enter), 32'(m_enter));
      check("R8 lp_exit", 32'(lp_exit), 32'(m_exit));
      check("R8 req_go", 32'(req_go), 32'(req_valid && m_state == 0));
      check("R9 freq_chg_ack", 32'(freq_chg_ack), 32'(freq_chg_req && m_state == 0));
      check("R5 pm_word", 32'(pm_word), 32'(m_word));
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int mode, input int f);
    cfg_we = 1; cfg_mode = 3'(mode); cfg_freq_mhz = FREQ_W'(f);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_req();
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wake(input string tag);
    req_valid = 1;
    @(negedge clk);
    check({tag, " exit pulse"}, 32'(lp_exit), 32'd1);
    check({tag, " back active"}, 32'(lp_kind), 32'd0);
    check({tag, " go after exit"}, 32'(req_go), 32'd1);
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; freq_chg_req = 0; cfg_we = 0;
    cfg_mode = 0; cfg_freq_mhz = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_en = 1;

    // R1 reset state
    check("R1 pm_word", 32'(pm_word), 32'hF0FF);
    check("R1 lp_kind", 32'(lp_kind), 32'd0);
    check("R1 no cmds", 32'({lp_enter, lp_exit}), 32'd0);
    req_valid = 1; #1;
    check("R1 req_go passthrough", 32'(req_go), 32'd1);
    @(negedge clk); req_valid = 0;

    // R2/R6 clock stop at fast frequency: code 4, 128-cycle window
    cfg(1, 533);
    check("R2 fast word", 32'(pm_word), 32'h41FF);
    pulse_req();
    tick(127);
    check("R6 not yet clock stop", 32'(lp_kind), 32'd0);
    tick(1);
    check("R6 clock stop entered", 32'(lp_kind), 32'd1);
    check("R6 enter pulse", 32'(lp_enter), 32'd1);
    tick(1);
    check("R6 enter one cycle", 32'(lp_enter), 32'd0);

    // R8 wake, then R10 mid-count reconfiguration
    wake("R8");
    tick(50);
    cfg(4, 200);
    check("R5 pd word", 32'(pm_word), 32'hF4F0);
    tick(76);
    check("R10 old window kept", 32'(lp_kind), 32'd0);
    tick(1);
    check("R10 old mode entered", 32'(lp_kind), 32'd1);
    wake("R8 second");
    tick(7);
    check("R10 new window pending", 32'(lp_kind), 32'd0);
    tick(1);
    check("R10 power-down after restart", 32'(lp_kind), 32'd3);

    // R4 self-refresh clamp: slow code 0 raised to 6 -> 512 cycles
    cfg(2, 200);
    check("R4 sr word slow", 32'(pm_word), 32'hF26F);
    check("R4 still power-down", 32'(lp_kind), 32'd3);
    wake("R8 third");
    tick(511);
    check("R4 no early self-refresh", 32'(lp_kind), 32'd0);
    tick(1);
    check("R4 self-refresh entered", 32'(lp_kind), 32'd2);

    // R9 frequency change
    freq_chg_req = 1;
    @(negedge clk);
    check("R9 exit on freq change", 32'(lp_exit), 32'd1);
    check("R9 ack", 32'(freq_chg_ack), 32'd1);
    tick(600);
    check("R9 no entry during change", 32'(lp_kind), 32'd0);
    freq_chg_req = 0;
    tick(511);
    check("R9 resume counting", 32'(lp_kind), 32'd0);
    tick(1);
    check("R9 self-refresh restored", 32'(lp_kind), 32'd2);

    // R7 undefined and disabled modes
    cfg(3, 533);
    check("R7 mode3 word", 32'(pm_word), 32'hF3FF);
    wake("R8 fourth");
    tick(600);
    check("R7 mode3 no entry", 32'(lp_kind), 32'd0);
    cfg(7, 200);
    check("R7 mode7 word", 32'(pm_word), 32'hF7FF);
    tick(300);
    check("R7 mode7 no entry", 32'(lp_kind), 32'd0);

    // R2 threshold boundary and R3 small-timeout code
    cfg(1, 400);
    check("R2 at threshold fast", 32'(pm_word), 32'h41FF);
    cfg(1, 399);
    check("R3 below threshold code 0", 32'(pm_word), 32'h01FF);
    pulse_req();
    tick(7);
    check("R3 8-cycle window pending", 32'(lp_kind), 32'd0);
    tick(1);
    check("R3 8-cycle window entered", 32'(lp_kind), 32'd1);
    cfg(2, 533);
    check("R4 sr word fast", 32'(pm_word), 32'hF26F);
    wake("R8 fifth");
    tick(20);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule